// File: doc/BRIEF.md
# Two-Wire Memory with Mapped Potentiometer Wipers

This block is a two-wire serial slave that owns a 256-byte register array. Two bytes near the top of the array also act as live wiper codes for two digital potentiometers. Potentiometer 0 has 100 steps and potentiometer 1 has 256 steps. Both codes leave the block as plain digital output ports, ready for an analog resistor ladder. The storage is modelled as flops, and nothing in the block models programming time.

A bus master selects the device with a 7-bit address. The upper four bits are fixed and the lower three come from strap pins, so eight of these blocks can share one bus. Every transfer goes through an internal byte pointer. A write sets the pointer and then stores bytes. A read returns bytes from the pointer, either at once (current-address read) or after a pointer-setting write and a repeated START (random read). A write-protect input freezes both the array and the wipers. Board level pulls this input high, so an unconnected pin leaves the device protected.

The block runs on a fast system clock. It oversamples SCL and SDA and drives SDA through an active-high pull-down enable.

Top module: `potmem_top`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 1010b followed by `strap_i[2:0]`. For any other address it leaves SDA released (NACK) and ignores the rest of that transfer.
- R2: In a write transfer the first data byte loads the pointer. Each following byte is stored at the pointer and acknowledged.
- R3: The pointer increments after every data byte written or read, and wraps from FFh to 00h.
- R4: A read transfer returns the byte at the pointer, MSB first. Reading continues while the master acknowledges and ends on a master NACK. A read with no preceding pointer write starts at the current pointer.
- R5: While `wp_i` is 1, data bytes are still acknowledged and still advance the pointer, but neither the array nor either wiper output changes.
- R6: `wiper1_o` equals the byte stored at F8h. `wiper0_o` equals the byte stored at F9h, clamped to 99 when that byte exceeds 99. The stored F9h byte keeps its written value.
- R7: Writes to any address other than F8h and F9h leave both wiper outputs unchanged.
- R8: After reset every array byte is 00h, both wiper outputs are 0 and SDA is released.
- R9: The slave changes its SDA enable only while SCL is low. A START at any point restarts address reception, and a STOP returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 3 | Low three bits of the slave address |
| wp_i | input | 1 | Write protect, 1 = protected |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| wiper0_o | output | 7 | Potentiometer 0 wiper code, 0 to 99 |
| wiper1_o | output | 8 | Potentiometer 1 wiper code, 0 to 255 |

## Verification
The assertions assume a well-formed master. SCL stays low and high for several system clocks, so every SCL falling edge reaches the synchronizer long before the next rising edge. The master ends each read with a NACK before it issues STOP or a new START, so the slave is never pulling SDA low when a bus condition arrives. The bench drives every quarter bit period as eight system clocks and changes `wp_i` only between bytes while SCL is low, which keeps the write-protect window check valid.

// File: rtl/potmem_pkg.sv
`timescale 1ns/1ps
package potmem_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_PTR,
        ST_WDAT,
        ST_ACK,
        ST_RDAT,
        ST_RACK
    } st_e;

    typedef struct packed {
        st_e               st;
        st_e               nxt;
        logic [BYTE_W-1:0] shreg;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] ptr;
        logic              oe;
        logic              rd_more;
    } ctl_s;
endpackage

// File: rtl/potmem_sync.sv
`timescale 1ns/1ps
module potmem_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_sh_q, sda_sh_q;
    logic              scl_prev_q, sda_prev_q;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q   <= '1;
            sda_sh_q   <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sh_q   <= {scl_sh_q[STAGES-2:0], scl_i};
            sda_sh_q   <= {sda_sh_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_sh_q[STAGES-1];
            sda_prev_q <= sda_sh_q[STAGES-1];
        end
    end

    assign scl_s      = scl_sh_q[STAGES-1];
    assign sda_o      = sda_sh_q[STAGES-1];
    assign scl_rise_o = scl_s & ~scl_prev_q;
    assign scl_fall_o = ~scl_s & scl_prev_q;
    // bus conditions: SDA moves while SCL stays high
    assign start_o    = scl_s & scl_prev_q & sda_prev_q & ~sda_o;
    assign stop_o     = scl_s & scl_prev_q & ~sda_prev_q & sda_o;
endmodule

// File: rtl/potmem_array.sv
`timescale 1ns/1ps
module potmem_array
    import potmem_pkg::*;
#(
    parameter logic [BYTE_W-1:0] POT0_ADDR  = 8'hF9,
    parameter logic [BYTE_W-1:0] POT1_ADDR  = 8'hF8,
    parameter int                POT0_STEPS = 100
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [BYTE_W-1:0]             waddr_i,
    input  logic [BYTE_W-1:0]             wdata_i,
    input  logic [BYTE_W-1:0]             raddr_i,
    output logic [BYTE_W-1:0]             rdata_o,
    output logic [$clog2(POT0_STEPS)-1:0] wiper0_o,
    output logic [BYTE_W-1:0]             wiper1_o
);
    localparam int DEPTH  = 2 ** BYTE_W;
    localparam int POT0_W = $clog2(POT0_STEPS);

    logic [BYTE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o  = mem_q[raddr_i];
    assign wiper1_o = mem_q[POT1_ADDR];

    generate
        if (POT0_STEPS >= DEPTH) begin : g_full
            assign wiper0_o = mem_q[POT0_ADDR][POT0_W-1:0];
        end else begin : g_clamp
            localparam logic [BYTE_W-1:0] POT0_MAX = BYTE_W'(POT0_STEPS - 1);
            logic [BYTE_W-1:0] raw0;
            assign raw0 = mem_q[POT0_ADDR];
            always_comb begin
                if (raw0 > POT0_MAX) wiper0_o = POT0_MAX[POT0_W-1:0];
                else                 wiper0_o = raw0[POT0_W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/potmem_top.sv
`timescale 1ns/1ps
module potmem_top
    import potmem_pkg::*;
#(
    parameter int                        STRAP_W     = 3,
    parameter logic [BYTE_W-2-STRAP_W:0] DEV_ID      = 4'b1010,
    parameter logic [BYTE_W-1:0]         POT0_ADDR   = 8'hF9,
    parameter logic [BYTE_W-1:0]         POT1_ADDR   = 8'hF8,
    parameter int                        POT0_STEPS  = 100,
    parameter int                        SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          scl_i,
    input  logic                          sda_i,
    input  logic [STRAP_W-1:0]            strap_i,
    input  logic                          wp_i,
    output logic                          sda_oe_o,
    output logic [$clog2(POT0_STEPS)-1:0] wiper0_o,
    output logic [BYTE_W-1:0]             wiper1_o
);
    localparam logic [3:0] BITS = 4'(BYTE_W);

    logic              sda_s, rise_w, fall_w, start_w, stop_w;
    logic              we;
    logic [BYTE_W-1:0] rdata;
    ctl_s              d, q;

    potmem_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_o(sda_s), .scl_rise_o(rise_w), .scl_fall_o(fall_w),
        .start_o(start_w), .stop_o(stop_w)
    );

    potmem_array #(
        .POT0_ADDR(POT0_ADDR), .POT1_ADDR(POT1_ADDR), .POT0_STEPS(POT0_STEPS)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .we_i(we), .waddr_i(q.ptr),
        .wdata_i(q.shreg), .raddr_i(q.ptr), .rdata_o(rdata),
        .wiper0_o(wiper0_o), .wiper1_o(wiper1_o)
    );

    always_comb begin
        d  = q;
        we = 1'b0;
        if (start_w) begin
            d.st  = ST_DEV;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (stop_w) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            unique case (q.st)
                ST_DEV, ST_PTR, ST_WDAT: begin
                    if (rise_w && q.cnt < BITS) begin
                        d.shreg = {q.shreg[BYTE_W-2:0], sda_s};
                        d.cnt   = q.cnt + 4'd1;
                    end else if (fall_w && q.cnt == BITS) begin
                        d.cnt = '0;
                        d.oe  = 1'b1;
                        d.st  = ST_ACK;
                        if (q.st == ST_DEV) begin
                            d.nxt = q.shreg[0] ? ST_RDAT : ST_PTR;
                            if (q.shreg[BYTE_W-1:1] != {DEV_ID, strap_i}) begin
                                d.oe = 1'b0;
                                d.st = ST_IDLE;
                            end
                        end else if (q.st == ST_PTR) begin
                            d.ptr = q.shreg;
                            d.nxt = ST_WDAT;
                        end else begin
                            we    = ~wp_i;
                            d.ptr = q.ptr + 1'b1;
                            d.nxt = ST_WDAT;
                        end
                    end
                end
                ST_ACK: begin
                    if (fall_w) begin
                        d.st  = q.nxt;
                        d.cnt = '0;
                        if (q.nxt == ST_RDAT) begin
                            d.shreg = rdata;
                            d.oe    = ~rdata[BYTE_W-1];
                        end else begin
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_RDAT: begin
                    if (rise_w) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall_w) begin
                        if (q.cnt == BITS) begin
                            d.oe  = 1'b0;
                            d.ptr = q.ptr + 1'b1;
                            d.st  = ST_RACK;
                            d.cnt = '0;
                        end else begin
                            d.shreg = {q.shreg[BYTE_W-2:0], 1'b0};
                            d.oe    = ~q.shreg[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (rise_w) begin
                        d.rd_more = ~sda_s;
                    end else if (fall_w) begin
                        if (q.rd_more) begin
                            d.shreg = rdata;
                            d.oe    = ~rdata[BYTE_W-1];
                            d.st    = ST_RDAT;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, nxt: ST_IDLE, shreg: '0, cnt: '0,
                   ptr: '0, oe: 1'b0, rd_more: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;
endmodule

// File: rtl/potmem_chk.sv
`timescale 1ns/1ps
module potmem_chk #(
    parameter int POT0_STEPS = 100
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          scl_i,
    input logic                          wp_i,
    input logic                          stop,
    input logic                          sda_oe,
    input logic [$clog2(POT0_STEPS)-1:0] wiper0,
    input logic [7:0]                    wiper1
);
    // R5
    wp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wp_i) |-> ($stable(wiper0) && $stable(wiper1)));

    // R6
    wiper0_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wiper0 <= ($clog2(POT0_STEPS))'(POT0_STEPS - 1));

    // R9
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !sda_oe);
endmodule

bind potmem_top potmem_chk #(.POT0_STEPS(POT0_STEPS)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .wp_i(wp_i), .stop(stop_w),
    .sda_oe(sda_oe_o), .wiper0(wiper0_o), .wiper1(wiper1_o)
);

// File: tb/potmem_top_bench.sv
`timescale 1ns/1ps
module potmem_top_bench;
    localparam int Q = 8;
    localparam int NV = 9;
    // {addr, data, wp, expected readback}
    localparam logic [24:0] VEC [NV] = '{
        {8'h10, 8'hA5, 1'b0, 8'hA5},
        {8'h10, 8'h3C, 1'b1, 8'hA5},
        {8'h10, 8'h3C, 1'b0, 8'h3C},
        {8'hF9, 8'h32, 1'b0, 8'h32},
        {8'hF8, 8'hC8, 1'b0, 8'hC8},
        {8'hF8, 8'h11, 1'b1, 8'hC8},
        {8'hF7, 8'h7E, 1'b0, 8'h7E},
        {8'hFF, 8'h81, 1'b0, 8'h81},
        {8'h00, 8'h5A, 1'b0, 8'h5A}
    };

    logic       clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
    logic [2:0] strap = 3'b101;
    logic       sda_oe;
    logic [6:0] w0;
    logic [7:0] w1;
    wire        sda_line = m_sda & ~sda_oe;
    int         n_tests = 0, n_fail = 0;
    logic [7:0] ew0 = 8'd0, ew1 = 8'd0;
    logic [7:0] got;
    logic       ack;

    always #2.5 clk = ~clk;

    potmem_top u_potmem_top (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .strap_i(strap), .wp_i(wp), .sda_oe_o(sda_oe),
        .wiper0_o(w0), .wiper1_o(w1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; tick(Q); m_scl = 1'b1; tick(2 * Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
        b = sda_line; tick(Q); m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic a);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        get_bit(b);
        a = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic more);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        send_bit(~more);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] dv, input logic p);
        logic k;
        wp = p;
        i2c_start();
        send_byte({4'b1010, strap, 1'b0}, k); check("R1 address ack", k, 1);
        send_byte(a, k);                      check("R2 pointer ack", k, 1);
        send_byte(dv, k);                     check("R5 data ack", k, 1);
        i2c_stop();
        wp = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] dv);
        logic k;
        i2c_start();
        send_byte({4'b1010, strap, 1'b0}, k);
        send_byte(a, k);
        i2c_start();
        send_byte({4'b1010, strap, 1'b1}, k); check("R4 read address ack", k, 1);
        recv_byte(dv, 1'b0);
        i2c_stop();
    endtask

    initial begin
        tick(5);
        check("R8 reset sda_oe", sda_oe, 0);
        check("R8 reset wiper0", w0, 0);
        check("R8 reset wiper1", w1, 0);
        rst_n = 1'b1;
        tick(5);
        rd(8'h55, got); check("R8 reset array byte", got, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [7:0] a, dv, ex;
            logic       p;
            {a, dv, p, ex} = VEC[i];
            wr(a, dv, p);
            rd(a, got);
            check(p ? "R5 protected readback" : "R2 readback", got, ex);
            if (!p && a == 8'hF9) ew0 = (dv > 8'd99) ? 8'd99 : dv;
            if (!p && a == 8'hF8) ew1 = dv;
            check("R6/R7 wiper0", w0, ew0[6:0]);
            check("R6/R7 wiper1", w1, ew1);
        end

        // R6 clamp of potentiometer 0 code
        wr(8'hF9, 8'd150, 1'b0);
        check("R6 clamp wiper0", w0, 99);
        rd(8'hF9, got); check("R6 stored byte kept", got, 150);
        wr(8'hF9, 8'd99, 1'b0);  check("R6 wiper0 at 99", w0, 99);
        wr(8'hF9, 8'd100, 1'b0); check("R6 wiper0 at 100", w0, 99);

        // R1 wrong strap: NACK and transfer ignored
        i2c_start();
        send_byte({4'b1010, 3'b010, 1'b0}, ack); check("R1 mismatch nack", ack, 0);
        send_byte(8'h40, ack);
        send_byte(8'h99, ack);
        i2c_stop();
        rd(8'h40, got); check("R1 ignored write", got, 8'h00);

        // R3 sequential write wrapping FFh -> 00h
        i2c_start();
        send_byte({4'b1010, strap, 1'b0}, ack);
        send_byte(8'hFE, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack);
        i2c_stop();
        rd(8'hFF, got); check("R3 sequential FF", got, 8'h22);
        rd(8'h00, got); check("R3 wrap to 00", got, 8'h33);

        // R4 sequential read across the wrap
        i2c_start();
        send_byte({4'b1010, strap, 1'b0}, ack);
        send_byte(8'hFE, ack);
        i2c_start();
        send_byte({4'b1010, strap, 1'b1}, ack);
        recv_byte(got, 1'b1); check("R4 seq byte 0", got, 8'h11);
        recv_byte(got, 1'b1); check("R4 seq byte 1", got, 8'h22);
        recv_byte(got, 1'b0); check("R4 seq byte 2", got, 8'h33);
        i2c_stop();
        check("R9 released after read", sda_oe, 0);

        // R4 current-address read
        wr(8'h41, 8'h77, 1'b0);
        rd(8'h40, got);
        i2c_start();
        send_byte({4'b1010, strap, 1'b1}, ack);
        recv_byte(got, 1'b0);
        i2c_stop();
        check("R4 current address read", got, 8'h77);

        // R5 pointer advances over a protected byte
        i2c_start();
        send_byte({4'b1010, strap, 1'b0}, ack);
        send_byte(8'h30, ack);
        wp = 1'b1;
        send_byte(8'hAA, ack); check("R5 protected byte acked", ack, 1);
        wp = 1'b0;
        send_byte(8'hBB, ack);
        i2c_stop();
        rd(8'h30, got); check("R5 protected byte dropped", got, 8'h00);
        rd(8'h31, got); check("R5 pointer advanced", got, 8'hBB);

        // R9 START in the middle of a data byte
        i2c_start();
        send_byte({4'b1010, strap, 1'b0}, ack);
        send_byte(8'h50, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        i2c_start();
        send_byte({4'b1010, strap, 1'b0}, ack); check("R9 restart address ack", ack, 1);
        send_byte(8'h60, ack);
        send_byte(8'h12, ack);
        i2c_stop();
        rd(8'h50, got); check("R9 aborted byte not stored", got, 8'h00);
        rd(8'h60, got); check("R9 write after restart", got, 8'h12);
        check("R7 wiper1 untouched", w1, ew1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule